// File: doc/BRIEF.md
# Dual-Slope PWM Timer Channel

This block is an 8-bit timer channel that produces a centre-aligned pulse-width-modulated output. Its counter climbs from 0 to 255 and then falls back to 0, so one waveform period spans 510 counter steps and the pulse sits symmetrically around the bottom of the count. A compare value sets the pulse width. The counter steps only on ticks from a prescaler that divides the single system clock by 1, 8, 64, 256 or 1024, which gives a PWM frequency of f_clk / (N × 510).

The compare input acts as a holding buffer. The value in force is taken from it when the counter arrives at 255, or on any cycle while the timer is disabled, so a new duty cycle never cuts a period in half. At both turning points of the count the output is driven to the level that the slope ahead of it requires, whether or not a compare match happened. A compare value of 255 therefore releases cleanly, and a match skipped because the compare value moved behind the counter is made up for. A polarity input inverts the pin. Two single-cycle pulses report arrival at the bottom of the count and equality with the compare value in force.

Top module: `pcpwm_timer`

## Requirements
- R1: While reset is held and on the first cycle after it, the count is 0, both flags are 0 and the pin equals the polarity input (the output level is low).
- R2: Each step moves the count by one: 0,1,…,255,254,…,1,0,1,…; one period is 510 steps, so the spacing between bottom pulses is 510×N system clocks.
- R3: Prescale select codes 0,1,2,3,4 give N = 1, 8, 64, 256, 1024 (codes 5–7 also give 1024); in steady running the count changes every N system clocks.
- R4: A change of prescale select restarts the divider: the first step comes on the (N+1)-th clock edge after the change. After the timer is re-enabled the first step comes on the N-th edge.
- R5: While the enable input is low the count and the output level hold.
- R6: With polarity 0 the pin is high for 2×C steps of each period for compare value C below 255, and for the whole period when C is 255 (never high when C is 0).
- R7: With polarity 1 the pin is the complement of the polarity-0 waveform (high for 510 − 2×C steps, or never when C is 255).
- R8: The compare value in force loads from the compare input only on the step that brings the count to 255, or on any clock while disabled; a change of the input in mid-period leaves the output unaffected until then.
- R9: On arrival at 255 the output level becomes low, unless the compare value in force is 255, in which case it becomes high.
- R10: On arrival at 0 the output level becomes high, unless the compare value in force is 0, in which case it becomes low; this holds even when the down-slope match was skipped.
- R11: The bottom flag is high for exactly one system clock each time the count arrives at 0 from 1.
- R12: The compare flag is high for exactly one system clock each time the count arrives at the compare value in force: twice per period, once when that value is 0 or 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Timer run enable |
| ps_sel_i | input | 3 | Prescale select code |
| cmp_i | input | 8 | Compare value (holding buffer) |
| inv_i | input | 1 | Output polarity, 1 = inverted |
| pwm_o | output | 1 | PWM pin |
| cnt_o | output | 8 | Current counter value |
| cmp_flag_o | output | 1 | One-clock pulse on arrival at the compare value in force |
| ovf_flag_o | output | 1 | One-clock pulse on arrival at the bottom of the count |

## Verification
The hardest situations to reach are the skipped matches, because the double buffer normally stops the compare value from moving past the counter within a period. The stimulus uses the enable input to get there: it stops the timer on the down slope above the old compare value, writes a larger value while stopped so that it loads at once, and resumes, after which the pin must stay low until the bottom of the count forces it high. The release from a compare value of 255 is reached by writing a new value early in the up slope and watching that the pin stays high until the exact step that reaches 255.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;

    localparam int CNT_W = 8;
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_BOT = '0;

    typedef enum logic [2:0] {
        PS_DIV1    = 3'd0,
        PS_DIV8    = 3'd1,
        PS_DIV64   = 3'd2,
        PS_DIV256  = 3'd3,
        PS_DIV1024 = 3'd4
    } ps_code_e;

    // Planned next step of the counter.
    typedef struct packed {
        logic [CNT_W-1:0] nxt;     // value after the step
        logic             rising;  // step goes upward
    } cnt_step_t;

    function automatic int unsigned ps_ratio(input logic [2:0] code);
        case (code)
            PS_DIV1:   return 1;
            PS_DIV8:   return 8;
            PS_DIV64:  return 64;
            PS_DIV256: return 256;
            default:   return 1024;
        endcase
    endfunction

endpackage

// File: rtl/pcpwm_prescaler.sv
module pcpwm_prescaler #(
    parameter int PS_W = 10
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       en_i,
    input  logic [2:0] sel_i,
    output logic       tick_o
);
    import pcpwm_pkg::*;

    logic [PS_W-1:0] div_cnt;
    logic [2:0]      sel_q;
    logic            sel_chg;
    logic [PS_W-1:0] last_val;

    assign sel_chg  = (sel_i != sel_q);
    assign last_val = PS_W'(ps_ratio(sel_i) - 1);
    assign tick_o   = en_i && !sel_chg && (div_cnt == last_val);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            div_cnt <= '0;
            sel_q   <= '0;
        end else begin
            sel_q <= sel_i;
            if (!en_i || sel_chg || tick_o) begin
                div_cnt <= '0;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pcpwm_updown.sv
module pcpwm_updown (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic                        tick_i,
    output pcpwm_pkg::cnt_step_t        step_o,
    output logic [pcpwm_pkg::CNT_W-1:0] cnt_o
);
    import pcpwm_pkg::*;

    logic going_up;

    always_comb begin
        if (going_up) begin
            if (cnt_o == CNT_TOP) begin
                step_o.nxt    = CNT_TOP - 1'b1;
                step_o.rising = 1'b0;
            end else begin
                step_o.nxt    = cnt_o + 1'b1;
                step_o.rising = 1'b1;
            end
        end else begin
            if (cnt_o == CNT_BOT) begin
                step_o.nxt    = CNT_BOT + 1'b1;
                step_o.rising = 1'b1;
            end else begin
                step_o.nxt    = cnt_o - 1'b1;
                step_o.rising = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_o    <= CNT_BOT;
            going_up <= 1'b1;
        end else if (tick_i) begin
            cnt_o    <= step_o.nxt;
            going_up <= step_o.rising;
        end
    end

endmodule

// File: rtl/pcpwm_wavegen.sv
module pcpwm_wavegen (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic                        en_i,
    input  logic                        tick_i,
    input  pcpwm_pkg::cnt_step_t        step_i,
    input  logic [pcpwm_pkg::CNT_W-1:0] cmp_buf_i,
    output logic [pcpwm_pkg::CNT_W-1:0] act_cmp_o,
    output logic                        lvl_o,
    output logic                        cmp_hit_o,
    output logic                        bot_hit_o
);
    import pcpwm_pkg::*;

    logic             load_top;
    logic [CNT_W-1:0] act_nx;
    logic             lvl_nx;

    assign load_top = tick_i && step_i.rising && (step_i.nxt == CNT_TOP);
    assign act_nx   = (!en_i || load_top) ? cmp_buf_i : act_cmp_o;

    // Turning points force the level of the slope ahead; elsewhere a
    // match clears on the way up and sets on the way down.
    always_comb begin
        lvl_nx = lvl_o;
        if (step_i.nxt == CNT_TOP) begin
            lvl_nx = (act_nx == CNT_TOP);
        end else if (step_i.nxt == CNT_BOT) begin
            lvl_nx = (act_nx != CNT_BOT);
        end else if (step_i.nxt == act_nx) begin
            lvl_nx = !step_i.rising;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            act_cmp_o <= '0;
            lvl_o     <= 1'b0;
            cmp_hit_o <= 1'b0;
            bot_hit_o <= 1'b0;
        end else begin
            act_cmp_o <= act_nx;
            cmp_hit_o <= tick_i && (step_i.nxt == act_nx);
            bot_hit_o <= tick_i && !step_i.rising && (step_i.nxt == CNT_BOT);
            if (tick_i) begin
                lvl_o <= lvl_nx;
            end
        end
    end

endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer #(
    parameter int PS_W = 10
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       en_i,
    input  logic [2:0] ps_sel_i,
    input  logic [7:0] cmp_i,
    input  logic       inv_i,
    output logic       pwm_o,
    output logic [7:0] cnt_o,
    output logic       cmp_flag_o,
    output logic       ovf_flag_o
);
    import pcpwm_pkg::*;

    logic             tick;
    cnt_step_t        step;
    logic [CNT_W-1:0] act_cmp;
    logic             lvl;

    pcpwm_prescaler #(.PS_W(PS_W)) u_pre (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (en_i),
        .sel_i  (ps_sel_i),
        .tick_o (tick)
    );

    pcpwm_updown u_cnt (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_i (tick),
        .step_o (step),
        .cnt_o  (cnt_o)
    );

    pcpwm_wavegen u_wave (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .en_i      (en_i),
        .tick_i    (tick),
        .step_i    (step),
        .cmp_buf_i (cmp_i),
        .act_cmp_o (act_cmp),
        .lvl_o     (lvl),
        .cmp_hit_o (cmp_flag_o),
        .bot_hit_o (ovf_flag_o)
    );

    assign pwm_o = lvl ^ inv_i;

endmodule

// File: rtl/pcpwm_timer_chk.sv
module pcpwm_timer_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       en_i,
    input logic       inv_i,
    input logic       pwm_o,
    input logic [7:0] cnt_o,
    input logic       cmp_flag_o,
    input logic       ovf_flag_o,
    input logic [7:0] act_cmp
);

    assert_reset_state_R1: assert property (@(posedge clk_i)
        rst_i |=> (cnt_o == 8'd0 && !ovf_flag_o && !cmp_flag_o && pwm_o == inv_i));

    assert_unit_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && cnt_o != $past(cnt_o)) |->
        ((8'(cnt_o - $past(cnt_o)) == 8'd1) || (8'($past(cnt_o) - cnt_o) == 8'd1)));

    assert_hold_disabled_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$past(en_i)) |-> (cnt_o == $past(cnt_o)));

    assert_load_point_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && act_cmp != $past(act_cmp)) |->
        (!$past(en_i) || (cnt_o == 8'd255 && $past(cnt_o) == 8'd254)));

    assert_top_force_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && cnt_o == 8'd255 && $past(cnt_o) == 8'd254) |->
        (pwm_o == (inv_i ^ (act_cmp == 8'd255))));

    assert_bottom_force_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && cnt_o == 8'd0 && $past(cnt_o) == 8'd1) |->
        (pwm_o == (inv_i ^ (act_cmp != 8'd0))));

    assert_bottom_pulse_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && ovf_flag_o) |-> (cnt_o == 8'd0 && $past(cnt_o) == 8'd1));

    assert_compare_pulse_R12: assert property (@(posedge clk_i) disable iff (rst_i)
        cmp_flag_o |-> (cnt_o == act_cmp));

endmodule

bind pcpwm_timer pcpwm_timer_chk u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .en_i       (en_i),
    .inv_i      (inv_i),
    .pwm_o      (pwm_o),
    .cnt_o      (cnt_o),
    .cmp_flag_o (cmp_flag_o),
    .ovf_flag_o (ovf_flag_o),
    .act_cmp    (act_cmp)
);

// File: tb/pcpwm_timer_bench.sv
module pcpwm_timer_bench;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [2:0] ps_sel = 3'd0;
    logic [7:0] cmp = 8'd0;
    logic       inv = 1'b0;
    logic       pwm;
    logic [7:0] cnt;
    logic       cmpf;
    logic       ovf;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pcpwm_timer u_pcpwm_timer (
        .clk_i      (clk),
        .rst_i      (rst),
        .en_i       (en),
        .ps_sel_i   (ps_sel),
        .cmp_i      (cmp),
        .inv_i      (inv),
        .pwm_o      (pwm),
        .cnt_o      (cnt),
        .cmp_flag_o (cmpf),
        .ovf_flag_o (ovf)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Return at the negedge where the count has just arrived at v on the given slope.
    task automatic wait_cnt(input string req, input int v, input bit down);
        int prev;
        bit ok;
        prev = int'(cnt);
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (int'(cnt) == v && prev == (down ? v + 1 : v - 1)) begin
                ok = 1'b1;
                break;
            end
            prev = int'(cnt);
        end
        if (!ok) chk({req, " count not reached"}, 0, 1);
    endtask

    task automatic configure(input int c, input bit iv, input logic [2:0] sel);
        @(negedge clk);
        en = 1'b0;
        cmp = 8'(c);
        inv = iv;
        ps_sel = sel;
        repeat (2) @(negedge clk);
        en = 1'b1;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 count", int'(cnt), 0);
        chk("R1 pin", int'(pwm), 0);
        chk("R1 flags", int'(ovf) + int'(cmpf), 0);
    endtask

    task automatic t_duty(input int c, input bit iv);
        int hi, ov, cm, ex;
        configure(c, iv, 3'd0);
        repeat (1100) @(negedge clk);
        hi = 0; ov = 0; cm = 0;
        repeat (510) begin
            @(negedge clk);
            hi += int'(pwm);
            ov += int'(ovf);
            cm += int'(cmpf);
        end
        ex = (c == 255) ? 510 : 2 * c;
        if (iv) begin
            ex = 510 - ex;
            chk($sformatf("R7 high time c=%0d", c), hi, ex);
        end else begin
            chk($sformatf("R6 high time c=%0d", c), hi, ex);
        end
        chk($sformatf("R11 bottom pulses c=%0d", c), ov, 1);
        chk($sformatf("R12 compare pulses c=%0d", c), cm, (c == 0 || c == 255) ? 1 : 2);
    endtask

    task automatic t_sequence;
        configure(100, 1'b0, 3'd0);
        wait_cnt("R2", 255, 1'b0);
        @(negedge clk);
        chk("R2 turn at top", int'(cnt), 254);
        wait_cnt("R2", 0, 1'b1);
        @(negedge clk);
        chk("R2 turn at bottom", int'(cnt), 1);
    endtask

    task automatic t_ovf_gap(input logic [2:0] sel, input int n);
        int gap;
        bit seen;
        configure(128, 1'b0, sel);
        seen = 1'b0;
        for (int i = 0; i < 5000 * n && !seen; i++) begin
            @(negedge clk);
            seen = ovf;
        end
        gap = 0;
        seen = 1'b0;
        for (int i = 0; i < 1000 * n && !seen; i++) begin
            @(negedge clk);
            gap++;
            seen = ovf;
        end
        chk($sformatf("R2 bottom spacing N=%0d", n), gap, 510 * n);
    endtask

    task automatic t_prescaled_duty;
        int hi, ov;
        configure(128, 1'b0, 3'd1);
        repeat (8200) @(negedge clk);
        hi = 0; ov = 0;
        repeat (4080) begin
            @(negedge clk);
            hi += int'(pwm);
            ov += int'(ovf);
        end
        chk("R6 high time N=8 c=128", hi, 2048);
        chk("R11 one-clock bottom pulse N=8", ov, 1);
    endtask

    task automatic t_step(input logic [2:0] sel, input int n);
        logic [7:0] last;
        int k;
        configure(50, 1'b0, sel);
        last = cnt;
        for (int i = 0; i < 3000 && cnt == last; i++) @(negedge clk);
        last = cnt;
        k = 0;
        for (int i = 0; i < 3000 && cnt == last; i++) begin
            @(negedge clk);
            k++;
        end
        chk($sformatf("R3 step interval code=%0d", sel), k, n);
    endtask

    task automatic t_restart;
        logic [7:0] last;
        int k;
        configure(50, 1'b0, 3'd1);
        repeat (30) @(negedge clk);
        last = cnt;
        for (int i = 0; i < 100 && cnt == last; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        ps_sel = 3'd2;
        last = cnt;
        k = 0;
        for (int i = 0; i < 200 && cnt == last; i++) begin
            @(negedge clk);
            k++;
        end
        chk("R4 first step after select change", k, 65);
        en = 1'b0;
        repeat (10) @(negedge clk);
        ps_sel = 3'd1;
        repeat (3) @(negedge clk);
        en = 1'b1;
        last = cnt;
        k = 0;
        for (int i = 0; i < 200 && cnt == last; i++) begin
            @(negedge clk);
            k++;
        end
        chk("R4 first step after re-enable", k, 8);
    endtask

    task automatic t_release_top;
        configure(255, 1'b0, 3'd0);
        repeat (1100) @(negedge clk);
        wait_cnt("R8", 20, 1'b0);
        cmp = 8'd100;
        wait_cnt("R8", 150, 1'b0);
        chk("R8 old compare still in force", int'(pwm), 1);
        wait_cnt("R9", 254, 1'b0);
        chk("R9 high before top", int'(pwm), 1);
        @(negedge clk);
        chk("R9 forced low at top", int'(pwm), 0);
        wait_cnt("R9", 101, 1'b1);
        chk("R9 low above new compare", int'(pwm), 0);
        @(negedge clk);
        chk("R9 set at down match", int'(pwm), 1);
    endtask

    task automatic t_missed_down;
        logic [7:0] held;
        configure(100, 1'b0, 3'd0);
        repeat (1100) @(negedge clk);
        wait_cnt("R10", 150, 1'b1);
        en = 1'b0;
        cmp = 8'd200;
        held = cnt;
        repeat (20) @(negedge clk);
        chk("R5 count held", int'(cnt), int'(held));
        chk("R5 pin held", int'(pwm), 0);
        en = 1'b1;
        wait_cnt("R10", 10, 1'b1);
        chk("R10 skipped match leaves pin low", int'(pwm), 0);
        wait_cnt("R10", 0, 1'b1);
        chk("R10 forced high at bottom", int'(pwm), 1);
    endtask

    initial begin
        t_reset();
        t_sequence();
        t_duty(0, 1'b0);
        t_duty(1, 1'b0);
        t_duty(128, 1'b0);
        t_duty(254, 1'b0);
        t_duty(255, 1'b0);
        t_duty(0, 1'b1);
        t_duty(1, 1'b1);
        t_duty(128, 1'b1);
        t_duty(254, 1'b1);
        t_duty(255, 1'b1);
        t_ovf_gap(3'd0, 1);
        t_ovf_gap(3'd1, 8);
        t_prescaled_duty();
        t_step(3'd0, 1);
        t_step(3'd1, 8);
        t_step(3'd2, 64);
        t_step(3'd3, 256);
        t_step(3'd4, 1024);
        t_restart();
        t_release_top();
        t_missed_down();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule